// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Host Sequencer

This block drives an external 24-bit delta-sigma converter over a four-wire serial link. It acts as the link master and turns short user requests into the byte sequences the converter expects. There are four requests: write the channel-select register, resynchronise the digital filter, run a self-calibration, and stream a given number of conversion results. The serial clock comes from the system clock through an integer divider. The converter's active-low data-ready line passes through a two-flop synchroniser, and the block detects its falling edges.

After the last clock of every command, the block waits a guard interval before it clocks the next byte. This interval is counted in converter oscillator periods by a separate clock-enable. A resynchronise request always sends a wake command after the filter-sync command. The first result produced after a self-calibration is read but not passed on.

Results leave the block on a valid/ready stream. A word stays on `smp_data` with `smp_valid` high until the consumer accepts it with `smp_ready`. While a word is still waiting, the block starts no new readout. It remembers a single data-ready edge and fetches that result once the output slot is free. Requests use a plain valid/ready pair, and `req_ready` is high only when the block is idle and not powered down.

Top module: `adc_host_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `smp_valid` and `busy` are low, and `req_ready` is high.
- R2: The serial link uses clock polarity 0, phase 1. The clock idles low. The master changes `mosi` only at rising clock edges and samples `miso` at falling edges. Bytes go out most significant bit first.
- R3: A configure request (`req_op`=0) sends three bytes in one command: 0x51 (write base 0x50 OR register address 1), 0x00, then `req_data`.
- R4: Between the last falling clock edge of a command and the next rising clock edge there are at least GUARD_OSC oscillator periods (GUARD_OSC×OSC_DIV system cycles; 32 by default).
- R5: A resynchronise request (`req_op`=1) sends 0xFC, waits the guard interval, then sends 0xFB, followed by another guard interval.
- R6: Chip select falls when a request is accepted and stays low through every byte and guard interval of that request. It rises exactly once, at the end of the request, and only while the clock is low.
- R7: A calibrate request (`req_op`=2) sends 0xF0 and waits the guard interval. It then stays busy until a data-ready falling edge marks the end of the calibration.
- R8: A stream request (`req_op`=3) sends 0x03 once. On each data-ready falling edge it then clocks 24 bits while sending 0xFF filler bytes. It assembles the result most significant byte first and reports `req_data`+1 results.
- R9: The first result read after a calibration is dropped. A stream started with no calibration before it reports its first result.
- R10: While `smp_valid` is high and `smp_ready` is low, `smp_valid` and `smp_data` hold. No new readout starts while a word waits.
- R11: While `pwr_down` is high the serial clock does not change and `req_ready` is low.
- R12: An accepted request makes `busy` high on the next cycle, and `req_ready` stays low until the request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Converter powered down; hold all serial traffic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 configure, 1 resynchronise, 2 calibrate, 3 stream |
| req_data | input | 8 | Register value (configure) or result count minus one (stream) |
| busy | output | 1 | A request is in progress |
| smp_valid | output | 1 | Result word available |
| smp_ready | input | 1 | Consumer accepts the result word |
| smp_data | output | 24 | Conversion result |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench models the converter's serial side. It logs every byte with the cycle numbers of its first and last clock edges, and it measures the gap from a command's last falling edge to the next rising edge. A sequencer that counted the guard in system cycles, or skipped it before the wake byte, would leave a gap shorter than 32 cycles. Streams run under random back-pressure after a calibration and without one. A design that forgot the discard would report one word too many, and one that discarded unconditionally would lose the first word of a plain stream. A readout that started while a word was still waiting would overwrite it. Power-down is raised while a data-ready edge is pending, and a design that kept clocking would show serial clock edges during that window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    OP_CFG    = 2'd0,
    OP_SYNC   = 2'd1,
    OP_CAL    = 2'd2,
    OP_STREAM = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_GUARD,
    S_WAIT_RDY
  } seq_st_e;

  localparam logic [7:0] BYTE_FSYNC = 8'hFC;
  localparam logic [7:0] BYTE_WAKE  = 8'hFB;
  localparam logic [7:0] BYTE_CAL   = 8'hF0;
endpackage

// File: rtl/adc_spi_shifter.sv
// Mode-1 byte shifter: mosi launched on the rising half, miso captured on the falling half.
module adc_spi_shifter #(
  parameter int HALF_DIV = 4,
  parameter int W        = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PW = $clog2(2 * W);

  logic [CW-1:0] div;
  logic [PW-1:0] ph;
  logic [W-1:0]  tx_sh;
  logic          active;
  logic          tick;

  assign tick = active && en && (div == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      ph     <= '0;
      tx_sh  <= '0;
      active <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        tx_sh  <= tx;
        div    <= '0;
        ph     <= '0;
      end else if (active && en) begin
        if (tick) begin
          div <= '0;
          if (!ph[0]) begin
            sclk  <= 1'b1;
            mosi  <= tx_sh[W-1];
            tx_sh <= {tx_sh[W-2:0], 1'b0};
          end else begin
            sclk <= 1'b0;
            rx   <= {rx[W-2:0], miso};
            if (ph == PW'(2 * W - 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
          ph <= ph + 1'b1;
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_guard_timer.sv
// Counts converter oscillator periods from a free-running clock-enable.
module adc_guard_timer #(
  parameter int OSC_DIV   = 8,
  parameter int GUARD_OSC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int OCW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam int GW  = $clog2(GUARD_OSC + 2);

  logic [OCW-1:0] ocnt;
  logic [GW-1:0]  gcnt;
  logic           run;
  logic           osc_ce;

  assign osc_ce = (ocnt == OCW'(OSC_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocnt <= '0;
    else if (osc_ce) ocnt <= '0;
    else ocnt <= ocnt + 1'b1;
  end

  // GUARD_OSC+1 enables are counted so the full-period minimum is never undercut.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        gcnt <= '0;
      end else if (run && osc_ce) begin
        if (gcnt == GW'(GUARD_OSC)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq #(
  parameter int         SCLK_HALF = 4,
  parameter int         OSC_DIV   = 8,
  parameter int         GUARD_OSC = 4,
  parameter int         DW        = 24,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] WR_BASE   = 8'h50,
  parameter logic [3:0] CH_ADDR   = 4'h1,
  parameter logic [7:0] CONT_CMD  = 8'h03,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [CNT_W-1:0] req_data,
  output logic             busy,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [DW-1:0]    smp_data,
  input  logic             drdy_n,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  import adc_seq_pkg::*;

  localparam int NBYTE = DW / 8;
  localparam int IW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  seq_st_e          st;
  op_e              op;
  logic             stage;
  logic [IW-1:0]    bidx, last_idx;
  logic [7:0]       cb [NBYTE];
  logic [CNT_W:0]   remain;
  logic             discard, pend, is_read;
  logic [DW-1:0]    acc;
  logic [DW-1:0]    word_next;
  logic [2:0]       rdy_q;
  logic             rdy_fall;
  logic             sh_start, sh_done, g_start, g_done, last_b;
  logic [7:0]       sh_rx;
  logic             cs_q;

  // data-ready synchroniser and falling-edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '1;
    else rdy_q <= {rdy_q[1:0], drdy_n};
  end
  assign rdy_fall = rdy_q[2] & ~rdy_q[1];

  assign last_b    = (bidx == last_idx);
  assign sh_start  = (st == S_LOAD) && !pwr_down;
  assign g_start   = (st == S_SHIFT) && sh_done && last_b && !is_read;
  assign word_next = {acc[DW-9:0], sh_rx};
  assign busy      = (st != S_IDLE);
  assign req_ready = (st == S_IDLE) && !pwr_down;
  assign cs_n      = cs_q;

  adc_spi_shifter #(.HALF_DIV(SCLK_HALF), .W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(!pwr_down), .start(sh_start), .tx(cb[bidx]),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(sh_done), .rx(sh_rx)
  );

  adc_guard_timer #(.OSC_DIV(OSC_DIV), .GUARD_OSC(GUARD_OSC)) u_guard (
    .clk(clk), .rst_n(rst_n), .start(g_start), .done(g_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op        <= OP_CFG;
      stage     <= 1'b0;
      bidx      <= '0;
      last_idx  <= '0;
      for (int i = 0; i < NBYTE; i++) cb[i] <= '0;
      remain    <= '0;
      discard   <= 1'b0;
      pend      <= 1'b0;
      is_read   <= 1'b0;
      acc       <= '0;
      cs_q      <= 1'b1;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      if (rdy_fall) pend <= 1'b1;
      if (smp_valid && smp_ready) smp_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            op      <= op_e'(req_op);
            cs_q    <= 1'b0;
            pend    <= 1'b0;
            bidx    <= '0;
            stage   <= 1'b0;
            is_read <= 1'b0;
            st      <= S_LOAD;
            unique case (op_e'(req_op))
              OP_CFG: begin
                cb[0]    <= WR_BASE | {4'h0, CH_ADDR};
                cb[1]    <= 8'h00;
                cb[2]    <= 8'(req_data);
                last_idx <= IW'(2);
              end
              OP_SYNC: begin
                cb[0]    <= BYTE_FSYNC;
                last_idx <= '0;
              end
              OP_CAL: begin
                cb[0]    <= BYTE_CAL;
                last_idx <= '0;
              end
              default: begin
                cb[0]    <= CONT_CMD;
                last_idx <= '0;
                remain   <= {1'b0, req_data} + 1'b1;
              end
            endcase
          end
        end
        S_LOAD: if (!pwr_down) st <= S_SHIFT;
        S_SHIFT: begin
          if (sh_done) begin
            if (is_read) acc <= word_next;
            if (!last_b) begin
              bidx <= bidx + 1'b1;
              st   <= S_LOAD;
            end else if (!is_read) begin
              st <= S_GUARD;
            end else begin
              is_read <= 1'b0;
              if (discard) begin
                discard <= 1'b0;
                st      <= S_WAIT_RDY;
              end else begin
                smp_valid <= 1'b1;
                smp_data  <= word_next;
                remain    <= remain - 1'b1;
                if (remain == (CNT_W + 1)'(1)) begin
                  st   <= S_IDLE;
                  cs_q <= 1'b1;
                end else begin
                  st <= S_WAIT_RDY;
                end
              end
            end
          end
        end
        S_GUARD: begin
          if (g_done) begin
            unique case (op)
              OP_SYNC: begin
                if (!stage) begin
                  stage <= 1'b1;
                  cb[0] <= BYTE_WAKE;
                  bidx  <= '0;
                  st    <= S_LOAD;
                end else begin
                  st   <= S_IDLE;
                  cs_q <= 1'b1;
                end
              end
              OP_CFG: begin
                st   <= S_IDLE;
                cs_q <= 1'b1;
              end
              default: st <= S_WAIT_RDY;
            endcase
          end
        end
        S_WAIT_RDY: begin
          if (op == OP_CAL) begin
            if (pend) begin
              pend    <= 1'b0;
              discard <= 1'b1;
              st      <= S_IDLE;
              cs_q    <= 1'b1;
            end
          end else if (pend && !smp_valid) begin
            pend     <= 1'b0;
            is_read  <= 1'b1;
            bidx     <= '0;
            last_idx <= IW'(NBYTE - 1);
            for (int i = 0; i < NBYTE; i++) cb[i] <= FILL_BYTE;
            st       <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_seq_chk.sv
module adc_host_seq_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          req_valid,
  input logic          req_ready,
  input logic          busy,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [DW-1:0] smp_data,
  input logic          sclk,
  input logic          cs_n,
  input logic          mosi
);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(mosi));

  // R6
  cs_idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R10
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

  // R11
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> $stable(sclk));

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
endmodule

bind adc_host_seq adc_host_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .req_valid(req_valid),
  .req_ready(req_ready), .busy(busy), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_data(smp_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/adc_host_seq_tb.sv
module adc_host_seq_tb;
  localparam int CLK_P     = 10;
  localparam int GUARD_CYC = 4 * 8;

  logic clk = 0, rst_n = 0, pwr_down = 0, req_valid = 0, smp_ready = 0;
  logic drdy_n = 1, miso = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_data = 0;
  logic req_ready, busy, smp_valid, sclk, cs_n, mosi;
  logic [23:0] smp_data;

  adc_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_data(req_data), .busy(busy),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .drdy_n(drdy_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // expected byte values, derived from the requirements
  function automatic logic [7:0] cfg_head(); return 8'h50 | 8'h01; endfunction
  function automatic logic [7:0] stream_cmd(); return 8'h03; endfunction

  // converter serial model
  logic [7:0]  blog [0:255];
  int          bstart [0:255];
  int          bend [0:255];
  int          nlog = 0, sl_bits = 0, cur_start = 0, rise_cnt = 0, rd_base = 0, cs_rise = 0;
  logic [7:0]  sl_sh = 0;
  logic [23:0] cur_word = 0;

  always @(negedge drdy_n) rd_base = rise_cnt;
  always @(posedge cs_n) cs_rise++;

  always @(posedge sclk) begin
    int idx;
    if (!cs_n) begin
      if (sl_bits == 0) cur_start = cyc;
      idx = rise_cnt - rd_base;
      miso <= (idx < 24) ? cur_word[23 - idx] : 1'b0;
    end
    rise_cnt++;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      sl_sh = {sl_sh[6:0], mosi};
      sl_bits++;
      if (sl_bits == 8) begin
        blog[nlog[7:0]]   = sl_sh;
        bstart[nlog[7:0]] = cur_start;
        bend[nlog[7:0]]   = cyc;
        nlog++;
        sl_bits = 0;
      end
    end
  end

  // output consumer with random back-pressure
  int          ready_pct = 100;
  logic [23:0] got [0:63];
  int          ngot = 0;
  bit          prev_hold = 0;
  logic [23:0] prev_data = 0;
  always @(negedge clk) begin
    bit r;
    if (prev_hold) chk(smp_valid && smp_data == prev_data, "R10 hold", {7'd0, smp_valid, smp_data}, {8'd1, prev_data});
    r = ($urandom % 100) < ready_pct;
    if (smp_valid && r && ngot < 64) begin
      got[ngot] = smp_data;
      ngot++;
    end
    prev_hold = rst_n && smp_valid && !r;
    prev_data = smp_data;
    smp_ready = r;
  end

  task automatic do_req(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = o; req_data = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_bytes(input int n);
    while (nlog < n) @(negedge clk);
  endtask

  task automatic pulse_drdy(input logic [23:0] w);
    cur_word = w;
    drdy_n = 0;
    repeat (4) @(negedge clk);
    drdy_n = 1;
  endtask

  // stream test: total words offered, first dropped if drop=1
  task automatic run_stream(input int n_rep, input bit drop);
    logic [23:0] expw [0:15];
    int n0, g0, nexp, total;
    n0 = nlog; g0 = ngot; nexp = 0;
    total = n_rep + (drop ? 1 : 0);
    do_req(2'd3, 8'(n_rep - 1));
    wait_bytes(n0 + 1);
    chk(blog[n0[7:0]] == stream_cmd(), "R8 stream command", blog[n0[7:0]], stream_cmd());
    for (int k = 0; k < total; k++) begin
      logic [23:0] w;
      int nb;
      repeat (10 + $urandom % 30) @(negedge clk);
      w = 24'($urandom);
      if (!(drop && k == 0)) begin expw[nexp] = w; nexp++; end
      pulse_drdy(w);
      nb = n0 + 1 + 3 * (k + 1);
      wait_bytes(nb);
      for (int j = 1; j <= 3; j++)
        chk(blog[8'(nb - j)] == 8'hFF, "R8 filler", blog[8'(nb - j)], 8'hFF);
      repeat (4) @(negedge clk);
      while (smp_valid) @(negedge clk);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk(ngot - g0 == n_rep, drop ? "R9 count after cal" : "R9 count plain", ngot - g0, n_rep);
    for (int k = 0; k < nexp; k++)
      chk(got[g0 + k] == expw[k], drop ? "R9 word" : "R8 word", got[g0 + k], expw[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n0, c0, r0;
    logic [23:0] w;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R1 reset pins", {cs_n, sclk}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(!smp_valid && !busy && req_ready, "R1 reset flags", {smp_valid, busy, req_ready}, 3'b001);
    chk(cs_n == 1 && sclk == 0, "R1 idle pins", {cs_n, sclk}, 2'b10);

    // configure with random register values, R3 and R2 byte order
    for (int i = 0; i < 3; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      n0 = nlog;
      do_req(2'd0, d);
      wait_idle();
      chk(nlog == n0 + 3, "R3 byte count", nlog, n0 + 3);
      chk(blog[n0[7:0]] == cfg_head(), "R3 head byte", blog[n0[7:0]], cfg_head());
      chk(blog[8'(n0 + 1)] == 8'h00, "R3 count byte", blog[8'(n0 + 1)], 0);
      chk(blog[8'(n0 + 2)] == d, "R2 R3 data byte", blog[8'(n0 + 2)], d);
      if (n0 > 0)
        chk(bstart[n0[7:0]] - bend[8'(n0 - 1)] >= GUARD_CYC, "R4 gap between commands",
            bstart[n0[7:0]] - bend[8'(n0 - 1)], GUARD_CYC);
    end

    // resynchronise: FC, guard, FB; one chip-select rise
    n0 = nlog; c0 = cs_rise;
    do_req(2'd1, 8'h00);
    chk(busy && !req_ready, "R12 busy after accept", {busy, req_ready}, 2'b10);
    wait_bytes(n0 + 2);
    chk(cs_rise == c0, "R6 cs held mid request", cs_rise, c0);
    wait_idle();
    @(negedge clk);
    chk(blog[n0[7:0]] == 8'hFC && blog[8'(n0 + 1)] == 8'hFB, "R5 sync bytes",
        {blog[n0[7:0]], blog[8'(n0 + 1)]}, 16'hFCFB);
    chk(bstart[8'(n0 + 1)] - bend[n0[7:0]] >= GUARD_CYC, "R4 R5 guard before wake",
        bstart[8'(n0 + 1)] - bend[n0[7:0]], GUARD_CYC);
    chk(cs_rise == c0 + 1 && cs_n, "R6 single rise at end", cs_rise, c0 + 1);

    // calibration holds busy until data-ready falls
    n0 = nlog;
    do_req(2'd2, 8'h00);
    wait_bytes(n0 + 1);
    chk(blog[n0[7:0]] == 8'hF0, "R7 cal byte", blog[n0[7:0]], 8'hF0);
    repeat (200) @(negedge clk);
    chk(busy == 1, "R7 busy until ready", busy, 1);
    pulse_drdy(24'h0);
    wait_idle();
    chk(busy == 0 && nlog == n0 + 1, "R7 done without traffic", nlog, n0 + 1);

    // stream after calibration with back-pressure: first word dropped
    ready_pct = 40;
    run_stream(2 + int'($urandom % 3), 1'b1);
    // plain stream: nothing dropped
    ready_pct = 70;
    run_stream(1 + int'($urandom % 4), 1'b0);
    ready_pct = 100;

    // power-down while idle: no acceptance
    @(negedge clk);
    pwr_down = 1;
    @(negedge clk);
    chk(req_ready == 0, "R11 ready low in power-down", req_ready, 0);
    n0 = nlog; r0 = rise_cnt;
    req_op = 2'd1; req_valid = 1;
    repeat (20) @(negedge clk);
    req_valid = 0;
    chk(!busy && nlog == n0 && rise_cnt == r0, "R11 request ignored", {busy, 8'(nlog - n0)}, 0);
    pwr_down = 0;

    // power-down with a pending data-ready edge
    n0 = nlog; c0 = ngot;
    do_req(2'd3, 8'h00);
    wait_bytes(n0 + 1);
    repeat (60) @(negedge clk);
    pwr_down = 1;
    r0 = rise_cnt;
    w = 24'($urandom);
    pulse_drdy(w);
    repeat (300) @(negedge clk);
    chk(rise_cnt == r0 && nlog == n0 + 1, "R11 clock frozen", rise_cnt - r0, 0);
    pwr_down = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(ngot == c0 + 1 && got[c0] == w, "R11 R8 word after release", got[c0], w);
    chk(cs_n == 1 && sclk == 0, "R6 idle after stream", {cs_n, sclk}, 2'b10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule